// File: doc/BRIEF.md
# Flash Controller Access Path Decoder

This block sits between the memory-mapped slave port of a serial flash controller and the controller's two data paths. Every bus access is classified as it arrives. An access whose address lies inside a programmable trigger window is treated as indirect and is served from the internal SRAM FIFO. Any other address is treated as direct: the access is forwarded to the flash array, with a programmable offset added to the bus address.

The window is set by a base address and a power-of-two size exponent. Its upper end saturates at the top of the 32-bit address space. The window does not map onto flash addresses in any way. During an indirect transfer, the flash address comes only from a dedicated read or write start register. A per-transfer counter advances that address by the beat size on each accepted FIFO beat. When the programmed byte count is used up, the block raises a one-cycle completion pulse for the interrupt logic.

An indirect access that cannot be served is stalled with a wait signal and is never dropped. This covers a full FIFO on a write, an empty FIFO on a read, no active transfer, and a direction that does not match the transfer.

Top module: `flash_path_decoder`

## Requirements
- R1: The trigger window covers the byte addresses from `cfg_trig_base` to `cfg_trig_base + 2^cfg_trig_exp - 1` inclusive, compared as unsigned numbers. For example, exponent 7 gives 128 bytes. A valid access inside the window is indirect. A valid access outside it is direct.
- R2: A direct access raises `dir_valid` in the same cycle. It copies `bus_write` to `dir_write` and drives `dir_addr = bus_addr + cfg_remap` modulo 2^32. A direct access is never stalled.
- R3: An indirect access never raises `dir_valid`, whatever its bus address. Its only effect is a FIFO push (write) or pop (read).
- R4: A trigger base of zero is legal. Address 0 is then inside the window.
- R5: When base plus window size passes 0xFFFF_FFFF, the window ends at 0xFFFF_FFFF and does not wrap around to low addresses.
- R6: A transfer is started by a one-cycle pulse on `start_rd` or `start_wr`. From the next cycle, `ind_flash_addr` equals `cfg_rd_start` or `cfg_wr_start` respectively. After each accepted beat, `ind_flash_addr` grows by 2^`bus_size` bytes, where `bus_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes.
- R7: In the following cases an indirect access holds `bus_wait` high and raises neither `fifo_push` nor `fifo_pop`: no transfer is active, its direction differs from the transfer's direction, the FIFO is full on a write, or the FIFO is empty on a read. Otherwise it is accepted in the same cycle, with no wait.
- R8: `ind_busy` is high from the cycle after a start until the cycle after the beat that brings the remaining count to zero or below. A beat larger than the remainder ends the transfer.
- R9: `ind_done` is high for exactly one cycle: the cycle after the final accepted beat.
- R10: The start address, the byte count and the direction are captured at the start. Start pulses and register changes while `ind_busy` is high have no effect on the running transfer. This includes a pulse that arrives in the same cycle as the final beat.
- R11: A start with `cfg_xfer_len` equal to zero is ignored. When both start pulses arrive together, the read start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_trig_base | input | 32 | Trigger window base address |
| cfg_trig_exp | input | 5 | Window size exponent (size = 2^exp bytes) |
| cfg_remap | input | 32 | Offset added to direct addresses |
| cfg_rd_start | input | 32 | Flash start address for indirect reads |
| cfg_wr_start | input | 32 | Flash start address for indirect writes |
| cfg_xfer_len | input | 16 | Byte count of an indirect transfer |
| start_rd | input | 1 | Pulse that starts an indirect read |
| start_wr | input | 1 | Pulse that starts an indirect write |
| bus_valid | input | 1 | Bus access present |
| bus_write | input | 1 | Bus access is a write |
| bus_addr | input | 32 | Bus byte address |
| bus_size | input | 2 | Beat size code (bytes = 2^code) |
| bus_wait | output | 1 | Stall of the current bus access |
| dir_valid | output | 1 | Direct access to the flash array |
| dir_write | output | 1 | Direct access is a write |
| dir_addr | output | 32 | Remapped flash address for a direct access |
| fifo_full | input | 1 | SRAM FIFO cannot take a write beat |
| fifo_empty | input | 1 | SRAM FIFO has no read beat |
| fifo_push | output | 1 | Indirect write beat into the FIFO |
| fifo_pop | output | 1 | Indirect read beat out of the FIFO |
| ind_busy | output | 1 | Indirect transfer active |
| ind_flash_addr | output | 32 | Flash address of the current indirect beat |
| ind_done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land on the same clock edge: the final indirect beat, which retires the transfer, and a new start pulse. The bench drives the last write beat and a `start_wr` pulse in the same cycle. It then expects the transfer to end with a single `ind_done` pulse, the new start to be dropped, and `ind_busy` to stay low. A direct access issued while an indirect transfer is stalled also shares cycles with the transfer counter. The per-cycle reference model judges both outcomes on every output.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

    localparam int FPD_ADDR_W = 32;
    localparam int FPD_EXP_W  = 5;
    localparam int FPD_LEN_W  = 16;

    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } beat_size_e;

endpackage

// File: rtl/fpd_window.sv
module fpd_window #(
    parameter int AW = 32,
    parameter int EW = 5
) (
    input  logic [AW-1:0] base,
    input  logic [EW-1:0] size_exp,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam logic [AW:0] ONE_X = {{AW{1'b0}}, 1'b1};

    logic [AW:0]   span;
    logic [AW:0]   top_ext;
    logic [AW-1:0] top_sat;

    always_comb begin
        span    = ONE_X << size_exp;
        top_ext = {1'b0, base} + span - ONE_X;
        // past the top of the address space the window is clipped
        top_sat = top_ext[AW] ? {AW{1'b1}} : top_ext[AW-1:0];
        hit     = (addr >= base) && (addr <= top_sat);
    end
endmodule

// File: rtl/fpd_remap.sv
module fpd_remap #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] bus_addr,
    input  logic [AW-1:0] offset,
    output logic [AW-1:0] flash_addr
);
    always_comb begin
        flash_addr = bus_addr + offset;
    end
endmodule

// File: rtl/fpd_xfer.sv
module fpd_xfer
    import fpd_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_rd,
    input  logic          start_wr,
    input  logic [AW-1:0] rd_start,
    input  logic [AW-1:0] wr_start,
    input  logic [LW-1:0] byte_cnt,
    input  logic          ind_req,
    input  logic          req_wr,
    input  beat_size_e    req_size,
    input  logic          fifo_full,
    input  logic          fifo_empty,
    output logic          accept,
    output logic          busy,
    output logic          is_wr,
    output logic [AW-1:0] cur_addr,
    output logic          done
);
    localparam logic [LW-1:0] ONE_L = {{(LW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic          active;
        logic          wr;
        logic [AW-1:0] addr;
        logic [LW-1:0] remain;
        logic          done;
    } xfer_t;

    xfer_t         st_q, st_d;
    logic [LW-1:0] beat_bytes;
    logic          dir_ok;

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        beat_bytes = ONE_L << req_size;
        dir_ok     = st_q.wr ? (req_wr && !fifo_full) : (!req_wr && !fifo_empty);
        accept     = ind_req && st_q.active && dir_ok;

        if (!st_q.active) begin
            if ((start_rd || start_wr) && (byte_cnt != '0)) begin
                st_d.active = 1'b1;
                st_d.wr     = !start_rd;
                st_d.addr   = start_rd ? rd_start : wr_start;
                st_d.remain = byte_cnt;
            end
        end else if (accept) begin
            st_d.addr = st_q.addr + AW'(beat_bytes);
            if (st_q.remain <= beat_bytes) begin
                st_d.active = 1'b0;
                st_d.remain = '0;
                st_d.done   = 1'b1;
            end else begin
                st_d.remain = st_q.remain - beat_bytes;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.active;
    assign is_wr    = st_q.wr;
    assign cur_addr = st_q.addr;
    assign done     = st_q.done;
endmodule

// File: rtl/flash_path_decoder.sv
module flash_path_decoder
    import fpd_pkg::*;
#(
    parameter int AW = FPD_ADDR_W,
    parameter int EW = FPD_EXP_W,
    parameter int LW = FPD_LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_trig_base,
    input  logic [EW-1:0] cfg_trig_exp,
    input  logic [AW-1:0] cfg_remap,
    input  logic [AW-1:0] cfg_rd_start,
    input  logic [AW-1:0] cfg_wr_start,
    input  logic [LW-1:0] cfg_xfer_len,
    input  logic          start_rd,
    input  logic          start_wr,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [1:0]    bus_size,
    output logic          bus_wait,
    output logic          dir_valid,
    output logic          dir_write,
    output logic [AW-1:0] dir_addr,
    input  logic          fifo_full,
    input  logic          fifo_empty,
    output logic          fifo_push,
    output logic          fifo_pop,
    output logic          ind_busy,
    output logic [AW-1:0] ind_flash_addr,
    output logic          ind_done
);
    logic       in_win;
    logic       ind_req;
    logic       accept;
    logic       xfer_wr;
    beat_size_e size_e;

    assign size_e  = beat_size_e'(bus_size);
    assign ind_req = bus_valid && in_win;

    fpd_window #(.AW(AW), .EW(EW)) u_window (
        .base     (cfg_trig_base),
        .size_exp (cfg_trig_exp),
        .addr     (bus_addr),
        .hit      (in_win)
    );

    fpd_remap #(.AW(AW)) u_remap (
        .bus_addr   (bus_addr),
        .offset     (cfg_remap),
        .flash_addr (dir_addr)
    );

    fpd_xfer #(.AW(AW), .LW(LW)) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_rd   (start_rd),
        .start_wr   (start_wr),
        .rd_start   (cfg_rd_start),
        .wr_start   (cfg_wr_start),
        .byte_cnt   (cfg_xfer_len),
        .ind_req    (ind_req),
        .req_wr     (bus_write),
        .req_size   (size_e),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .accept     (accept),
        .busy       (ind_busy),
        .is_wr      (xfer_wr),
        .cur_addr   (ind_flash_addr),
        .done       (ind_done)
    );

    always_comb begin
        dir_valid = bus_valid && !in_win;
        dir_write = bus_write;
        bus_wait  = ind_req && !accept;
        fifo_push = accept && xfer_wr;
        fifo_pop  = accept && !xfer_wr;
    end
endmodule

// File: rtl/fpd_checker.sv
module fpd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  bus_size,
    input logic        bus_wait,
    input logic        dir_valid,
    input logic        fifo_full,
    input logic        fifo_empty,
    input logic        fifo_push,
    input logic        fifo_pop,
    input logic        ind_busy,
    input logic [31:0] ind_flash_addr,
    input logic        ind_done
);
    assert_direct_nowait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dir_valid |-> !bus_wait);

    assert_path_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dir_valid |-> !(fifo_push || fifo_pop));

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push || fifo_pop) |=>
            ind_flash_addr == $past(ind_flash_addr) + (32'd1 << $past(bus_size)));

    assert_stall_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wait |-> !(fifo_push || fifo_pop));

    assert_no_push_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);

    assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);

    assert_idle_no_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ind_busy |-> !(fifo_push || fifo_pop));

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ind_done |-> !ind_busy);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ind_done |=> !ind_done);
endmodule

bind flash_path_decoder fpd_checker u_fpd_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_size       (bus_size),
    .bus_wait       (bus_wait),
    .dir_valid      (dir_valid),
    .fifo_full      (fifo_full),
    .fifo_empty     (fifo_empty),
    .fifo_push      (fifo_push),
    .fifo_pop       (fifo_pop),
    .ind_busy       (ind_busy),
    .ind_flash_addr (ind_flash_addr),
    .ind_done       (ind_done)
);

// File: tb/flash_path_decoder_bench.sv
`timescale 1ns/1ps
module flash_path_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_trig_base = '0;
    logic [4:0]  cfg_trig_exp = '0;
    logic [31:0] cfg_remap = '0;
    logic [31:0] cfg_rd_start = '0;
    logic [31:0] cfg_wr_start = '0;
    logic [15:0] cfg_xfer_len = '0;
    logic        start_rd = 1'b0;
    logic        start_wr = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        fifo_full = 1'b0;
    logic        fifo_empty = 1'b0;
    logic        bus_wait, dir_valid, dir_write;
    logic [31:0] dir_addr, ind_flash_addr;
    logic        fifo_push, fifo_pop, ind_busy, ind_done;

    always #10 clk = ~clk;

    flash_path_decoder u_flash_path_decoder (
        .clk(clk), .rst_n(rst_n),
        .cfg_trig_base(cfg_trig_base), .cfg_trig_exp(cfg_trig_exp),
        .cfg_remap(cfg_remap), .cfg_rd_start(cfg_rd_start),
        .cfg_wr_start(cfg_wr_start), .cfg_xfer_len(cfg_xfer_len),
        .start_rd(start_rd), .start_wr(start_wr),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wait(bus_wait), .dir_valid(dir_valid),
        .dir_write(dir_write), .dir_addr(dir_addr),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .fifo_push(fifo_push), .fifo_pop(fifo_pop),
        .ind_busy(ind_busy), .ind_flash_addr(ind_flash_addr),
        .ind_done(ind_done)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // reference model state
    bit     m_active = 0, m_wr = 0, m_done = 0, e_acc = 0;
    longint m_addr = 0, m_rem = 0;

    task automatic chk(bit ok, string tag, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit model_hit(longint a);
        longint lo = longint'(cfg_trig_base);
        longint hi = lo + (64'd1 << cfg_trig_exp) - 1;
        if (hi > 64'hFFFF_FFFF) hi = 64'hFFFF_FFFF;
        return (a >= lo) && (a <= hi);
    endfunction

    // compare every output, then advance one clock and the model with it
    task automatic step();
        bit     hit = model_hit(longint'(bus_addr));
        bit     e_dir = bus_valid && !hit;
        bit     ok_dir = m_wr ? (bus_write && !fifo_full) : (!bus_write && !fifo_empty);
        longint nbytes = 64'd1 << bus_size;
        bit     e_wait;
        e_acc  = bus_valid && hit && m_active && ok_dir;
        e_wait = bus_valid && hit && !e_acc;
        chk(dir_valid == e_dir, "R3 dir_valid", dir_valid, e_dir);
        if (e_dir) begin
            chk(longint'(dir_addr) == ((longint'(bus_addr) + longint'(cfg_remap)) & 64'hFFFF_FFFF),
                "R2 dir_addr", dir_addr, (longint'(bus_addr) + longint'(cfg_remap)) & 64'hFFFF_FFFF);
            chk(dir_write == bus_write, "R2 dir_write", dir_write, bus_write);
        end
        chk(bus_wait == e_wait, "R7 bus_wait", bus_wait, e_wait);
        chk(fifo_push == (e_acc && m_wr), "R7 fifo_push", fifo_push, e_acc && m_wr);
        chk(fifo_pop == (e_acc && !m_wr), "R7 fifo_pop", fifo_pop, e_acc && !m_wr);
        chk(ind_busy == m_active, "R8 ind_busy", ind_busy, m_active);
        chk(ind_done == m_done, "R9 ind_done", ind_done, m_done);
        if (m_active)
            chk(longint'(ind_flash_addr) == m_addr, "R6 ind_flash_addr", ind_flash_addr, m_addr);
        @(posedge clk);
        m_done = 0;
        if (!m_active) begin
            if ((start_rd || start_wr) && cfg_xfer_len != 0) begin
                m_active = 1;
                m_wr     = !start_rd;
                m_addr   = start_rd ? longint'(cfg_rd_start) : longint'(cfg_wr_start);
                m_rem    = longint'(cfg_xfer_len);
            end
        end else if (e_acc) begin
            m_addr = (m_addr + nbytes) & 64'hFFFF_FFFF;
            if (m_rem <= nbytes) begin
                m_active = 0; m_rem = 0; m_done = 1;
            end else begin
                m_rem = m_rem - nbytes;
            end
        end
        @(negedge clk);
    endtask

    task automatic drive(bit v, bit w, logic [31:0] a, logic [1:0] s);
        bus_valid = v; bus_write = w; bus_addr = a; bus_size = s;
        #2;
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // reset state
        chk(ind_busy == 0, "R8 reset busy", ind_busy, 0);
        chk(ind_done == 0, "R9 reset done", ind_done, 0);
        step();

        // R1 window edges with a 64-byte window
        cfg_trig_base = 32'h5001_0000; cfg_trig_exp = 5'd6; cfg_remap = 32'h5002_0000;
        drive(1, 0, 32'h5001_0010, 2); chk(dir_valid == 0, "R1 inside", dir_valid, 0); step();
        drive(1, 0, 32'h5001_003F, 0); chk(dir_valid == 0, "R1 last byte", dir_valid, 0); step();
        drive(1, 0, 32'h5001_0040, 0); chk(dir_valid == 1, "R1 past end", dir_valid, 1); step();
        drive(1, 1, 32'h5001_0000 - 1, 0); chk(dir_valid == 1, "R1 below base", dir_valid, 1); step();
        drive(1, 1, 32'h5030_0400, 2);
        chk(dir_addr == 32'hA032_0400, "R2 remap", dir_addr, 32'hA032_0400); step();
        drive(1, 0, 32'hF000_0000, 1); step();   // remap wraps modulo 2^32

        // R1 with exponent 7: 128 bytes
        cfg_trig_base = 32'h6000_0000; cfg_trig_exp = 5'd7;
        drive(1, 1, 32'h6000_007F, 0); chk(dir_valid == 0, "R1 exp7 last", dir_valid, 0); step();
        drive(1, 1, 32'h6000_0080, 0); chk(dir_valid == 1, "R1 exp7 out", dir_valid, 1); step();

        // R4 zero base
        cfg_trig_base = 32'h0;
        drive(1, 1, 32'h0000_0000, 2); chk(dir_valid == 0, "R4 addr 0", dir_valid, 0); step();
        drive(1, 1, 32'h0000_0080, 2); chk(dir_valid == 1, "R4 addr 0x80", dir_valid, 1); step();

        // R5 saturating end
        cfg_trig_base = 32'hFFFF_FF00; cfg_trig_exp = 5'd20;
        drive(1, 0, 32'hFFFF_FFFF, 0); chk(dir_valid == 0, "R5 top", dir_valid, 0); step();
        drive(1, 0, 32'h0000_0010, 0); chk(dir_valid == 1, "R5 no wrap", dir_valid, 1); step();
        drive(1, 0, 32'hFFFF_FEFF, 0); step();

        // indirect write: 16 bytes from 0x100, 4-byte beats
        cfg_trig_base = 32'h6000_0000; cfg_trig_exp = 5'd7;
        cfg_wr_start = 32'h100; cfg_xfer_len = 16'd16;
        drive(0, 0, 0, 0); start_wr = 1; step(); start_wr = 0;
        chk(ind_flash_addr == 32'h100, "R6 load start", ind_flash_addr, 32'h100);
        drive(1, 1, 32'h6000_0004, 2); step();
        fifo_full = 1; drive(1, 1, 32'h6000_0008, 2);
        chk(bus_wait == 1, "R7 full stall", bus_wait, 1); step();
        drive(1, 0, 32'h6000_0008, 2);
        chk(bus_wait == 1, "R7 wrong dir", bus_wait, 1); step();
        fifo_full = 0;
        drive(1, 0, 32'h1234_5678, 2); step();  // direct while transfer active
        cfg_wr_start = 32'h9999_0000; cfg_xfer_len = 16'd4;
        drive(1, 1, 32'h6000_0008, 2); start_wr = 1; step(); start_wr = 0;
        chk(ind_flash_addr == 32'h108, "R10 restart ignored", ind_flash_addr, 32'h108);
        drive(1, 1, 32'h6000_000C, 2); step();
        drive(1, 1, 32'h6000_0010, 2); step();
        drive(0, 0, 0, 0);
        chk(ind_done == 1, "R9 done pulse", ind_done, 1);
        chk(ind_busy == 0, "R8 busy cleared", ind_busy, 0); step();
        chk(ind_done == 0, "R9 pulse ends", ind_done, 0);
        drive(1, 1, 32'h6000_0000, 2); step();  // stall, no transfer

        // indirect read, mixed sizes, 6 bytes; overshoot ends it
        cfg_rd_start = 32'h2000; cfg_xfer_len = 16'd6;
        drive(0, 0, 0, 0); start_rd = 1; step(); start_rd = 0;
        cfg_rd_start = 32'h7777_0000;
        fifo_empty = 1; drive(1, 0, 32'h6000_0000, 0);
        chk(bus_wait == 1, "R7 empty stall", bus_wait, 1); step();
        fifo_empty = 0;
        drive(1, 0, 32'h6000_0000, 0); step();
        drive(1, 0, 32'h6000_0001, 2); step();
        drive(1, 0, 32'h6000_0005, 1); step();
        drive(0, 0, 0, 0); step(); step();

        // R11 zero length and both pulses
        cfg_xfer_len = 16'd0; start_wr = 1; step(); start_wr = 0;
        chk(ind_busy == 0, "R11 zero len", ind_busy, 0);
        cfg_xfer_len = 16'd2; cfg_rd_start = 32'h400; cfg_wr_start = 32'h800;
        start_rd = 1; start_wr = 1; step(); start_rd = 0; start_wr = 0;
        chk(ind_flash_addr == 32'h400, "R11 read wins", ind_flash_addr, 32'h400);
        drive(1, 0, 32'h6000_0000, 3); step();
        drive(0, 0, 0, 0); step();

        // final beat and new start in the same cycle
        cfg_xfer_len = 16'd4; cfg_wr_start = 32'hA0;
        start_wr = 1; step(); start_wr = 0;
        drive(1, 1, 32'h6000_0040, 2); start_wr = 1; step(); start_wr = 0;
        drive(0, 0, 0, 0);
        chk(ind_busy == 0, "R10 collision start dropped", ind_busy, 0);
        step(); step();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule